// File: doc/BRIEF.md
# Character Blink and Reverse Dot Selector

This block decides, for each dot of an on-screen text overlay, which level the video mixer drives: the character (foreground) level, the background box level, or no overlay at all. It takes the font bit of the current dot and the blink attribute of the character being drawn. It also takes a flag saying the dot lies inside the text window and the global display-control bits: display enable, blink enable, blink rate and reverse. From these it produces two mutually exclusive enables, one for the character level and one for the box level, registered one clock after the inputs.

A blink timer counts field strobes and holds the blink phase. The short rate changes phase every 15 fields and the long rate every 30 fields, which at about 60 fields per second gives blink periods of about 0.5 s and 1.0 s. A character whose attribute is set disappears during the hidden phase. If reverse is also on, the character does not disappear. It swaps between its reversed form in the visible phase and its plain form in the hidden phase.

Top module: `osd_blink_reverse`

## Requirements
- R1: While `disp_en` is 0, `char_on` and `box_on` are both 0 on the clock after the inputs.
- R2: While `win_valid` is 0, `char_on` and `box_on` are both 0 on the clock after the inputs.
- R3: With display on, window valid, reverse off and no blink in effect, the outputs one clock later are `char_on` = font bit and `box_on` = inverted font bit.
- R4: With `reverse_en` = 1 and no blink in effect, the outputs are inverted: `char_on` = inverted font bit and `box_on` = font bit.
- R5: A character with `attr_blink` = 0 is drawn the same way in both blink phases.
- R6: With `blink_en` = 1 and `reverse_en` = 0, a character with `attr_blink` = 1 gives `char_on` = 0 and `box_on` = 0 during the hidden phase, and is drawn normally during the visible phase.
- R7: With `blink_en` = 1 and `reverse_en` = 1, a character with `attr_blink` = 1 is drawn reversed in the visible phase and plain (`char_on` = font bit) in the hidden phase.
- R8: With `blink_slow` = 0, the phase goes from visible to hidden on the 15th field strobe after blinking is enabled, and back to visible on the 30th.
- R9: With `blink_slow` = 1, the phase goes to hidden on the 30th field strobe after blinking is enabled.
- R10: When `blink_en` is 0, the phase is visible at once and the field count restarts from zero.
- R11: After reset both outputs are 0 and the blink phase is visible.
- R12: `char_on` and `box_on` are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| font_px | input | 1 | Font bit of the current dot |
| attr_blink | input | 1 | Blink attribute of the current character |
| win_valid | input | 1 | Dot lies inside the text window |
| field_stb | input | 1 | One-cycle pulse per video field |
| disp_en | input | 1 | Global character display enable |
| blink_en | input | 1 | Global blink enable |
| blink_slow | input | 1 | 1 selects the long blink period, 0 the short one |
| reverse_en | input | 1 | Global character reverse |
| char_on | output | 1 | Drive character level on this dot |
| box_on | output | 1 | Drive background box level on this dot |

## Verification
The dot selection is driven with both font values under four setups: plain, reversed, attribute-blink in the hidden phase, and attribute-blink with reverse in the hidden phase. Comparing these separates blanking from swapping and shows which characters the phase touches. Display and window gating are tried with font bits that would otherwise light a dot. The timer is stepped one strobe at a time up to each toggle boundary at both rates, so a count that is one off is caught. A mid-period disable, followed by a fresh count, shows that the phase and the counter return to their start values.

// File: rtl/osd_blink_pkg.sv
package osd_blink_pkg;

    typedef enum logic [1:0] {
        LVL_NONE = 2'd0,
        LVL_CHAR = 2'd1,
        LVL_BOX  = 2'd2
    } dot_level_e;

    typedef struct packed {
        logic char_on;
        logic box_on;
    } dot_out_t;

    function automatic dot_out_t level_to_out(dot_level_e lvl);
        dot_out_t o;
        o.char_on = (lvl == LVL_CHAR);
        o.box_on  = (lvl == LVL_BOX);
        return o;
    endfunction

endpackage

// File: rtl/osd_blink_timer.sv
module osd_blink_timer #(
    parameter int SHORT_FIELDS = 15,
    parameter int LONG_FIELDS  = 30
) (
    input  logic clk,
    input  logic rst_n,
    input  logic field_stb,
    input  logic blink_en,
    input  logic blink_slow,
    output logic hidden
);
    localparam int CW = $clog2(LONG_FIELDS + 1);
    localparam logic [CW-1:0] SHORT_LAST = CW'(SHORT_FIELDS - 1);
    localparam logic [CW-1:0] LONG_LAST  = CW'(LONG_FIELDS - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          hidden;
    } tmr_t;

    tmr_t st_d, st_q;
    logic [CW-1:0] last_cnt;

    always_comb begin
        st_d     = st_q;
        last_cnt = blink_slow ? LONG_LAST : SHORT_LAST;
        if (!blink_en) begin
            st_d.cnt    = '0;
            st_d.hidden = 1'b0;
        end else if (field_stb) begin
            if (st_q.cnt >= last_cnt) begin
                st_d.cnt    = '0;
                st_d.hidden = ~st_q.hidden;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign hidden = st_q.hidden;

endmodule

// File: rtl/osd_dot_select.sv
module osd_dot_select
    import osd_blink_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic font_px,
    input  logic attr_blink,
    input  logic win_valid,
    input  logic disp_en,
    input  logic blink_en,
    input  logic reverse_en,
    input  logic hidden,
    output logic char_on,
    output logic box_on
);
    dot_out_t   out_d, out_q;
    dot_level_e lvl;
    logic       blink_now;
    logic       inv_now;
    logic       blank_now;
    logic       fg;

    always_comb begin
        blink_now = attr_blink && blink_en && hidden;
        // reversed characters swap form in the hidden phase instead of vanishing
        inv_now   = reverse_en && !blink_now;
        blank_now = blink_now && !reverse_en;
        fg        = font_px ^ inv_now;
        if (!(disp_en && win_valid) || blank_now) lvl = LVL_NONE;
        else if (fg)                              lvl = LVL_CHAR;
        else                                      lvl = LVL_BOX;
        out_d = level_to_out(lvl);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign char_on = out_q.char_on;
    assign box_on  = out_q.box_on;

endmodule

// File: rtl/osd_blink_reverse.sv
module osd_blink_reverse #(
    parameter int SHORT_FIELDS = 15,
    parameter int LONG_FIELDS  = 30
) (
    input  logic clk,
    input  logic rst_n,
    input  logic font_px,
    input  logic attr_blink,
    input  logic win_valid,
    input  logic field_stb,
    input  logic disp_en,
    input  logic blink_en,
    input  logic blink_slow,
    input  logic reverse_en,
    output logic char_on,
    output logic box_on
);
    logic blink_hidden;

    osd_blink_timer #(
        .SHORT_FIELDS(SHORT_FIELDS),
        .LONG_FIELDS (LONG_FIELDS)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .field_stb (field_stb),
        .blink_en  (blink_en),
        .blink_slow(blink_slow),
        .hidden    (blink_hidden)
    );

    osd_dot_select u_sel (
        .clk       (clk),
        .rst_n     (rst_n),
        .font_px   (font_px),
        .attr_blink(attr_blink),
        .win_valid (win_valid),
        .disp_en   (disp_en),
        .blink_en  (blink_en),
        .reverse_en(reverse_en),
        .hidden    (blink_hidden),
        .char_on   (char_on),
        .box_on    (box_on)
    );

endmodule

// File: rtl/osd_blink_reverse_chk.sv
module osd_blink_reverse_chk (
    input logic clk,
    input logic rst_n,
    input logic font_px,
    input logic attr_blink,
    input logic win_valid,
    input logic field_stb,
    input logic disp_en,
    input logic blink_en,
    input logic reverse_en,
    input logic hidden,
    input logic char_on,
    input logic box_on
);
    a_r1_disp_gate: assert property (@(posedge clk) disable iff (!rst_n)
        !disp_en |=> (!char_on && !box_on));

    a_r2_window_gate: assert property (@(posedge clk) disable iff (!rst_n)
        !win_valid |=> (!char_on && !box_on));

    a_r12_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(char_on && box_on));

    a_r10_blink_off_visible: assert property (@(posedge clk) disable iff (!rst_n)
        !blink_en |=> !hidden);

    a_r8_phase_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (blink_en && !field_stb) |=> $stable(hidden));

    a_r4_reverse_plain: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_en && win_valid && reverse_en && !attr_blink) |=> (char_on == !$past(font_px)));

    a_r3_normal_dot: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_en && win_valid && !reverse_en && !attr_blink) |=> (char_on == $past(font_px)));
endmodule

bind osd_blink_reverse osd_blink_reverse_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .font_px   (font_px),
    .attr_blink(attr_blink),
    .win_valid (win_valid),
    .field_stb (field_stb),
    .disp_en   (disp_en),
    .blink_en  (blink_en),
    .reverse_en(reverse_en),
    .hidden    (blink_hidden),
    .char_on   (char_on),
    .box_on    (box_on)
);

// File: tb/osd_blink_reverse_test.sv
`timescale 1ns/1ps
module osd_blink_reverse_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic font_px = 1'b0, attr_blink = 1'b0, win_valid = 1'b0, field_stb = 1'b0;
    logic disp_en = 1'b0, blink_en = 1'b0, blink_slow = 1'b0, reverse_en = 1'b0;
    logic char_on, box_on;
    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    osd_blink_reverse uut (
        .clk(clk), .rst_n(rst_n), .font_px(font_px), .attr_blink(attr_blink),
        .win_valid(win_valid), .field_stb(field_stb), .disp_en(disp_en),
        .blink_en(blink_en), .blink_slow(blink_slow), .reverse_en(reverse_en),
        .char_on(char_on), .box_on(box_on)
    );

    task automatic check(string req, logic ec, logic eb);
        checks++;
        if (char_on !== ec || box_on !== eb) begin
            errors++;
            $display("FAIL %s: char_on=%b box_on=%b expected char_on=%b box_on=%b",
                     req, char_on, box_on, ec, eb);
        end
    endtask

    // drive one dot, sample one clock later, after the edge
    task automatic dot(logic f, logic a);
        @(negedge clk);
        font_px = f; attr_blink = a;
        @(posedge clk); #1;
    endtask

    task automatic fields(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); field_stb = 1'b1;
            @(negedge clk); field_stb = 1'b0;
        end
    endtask

    task automatic set_ctl(logic d, logic w, logic b, logic s, logic r);
        @(negedge clk);
        disp_en = d; win_valid = w; blink_en = b; blink_slow = s; reverse_en = r;
    endtask

    task automatic t_reset;
        #1 check("R11 reset", 1'b0, 1'b0);
    endtask

    task automatic t_gating;
        set_ctl(0, 1, 0, 0, 0);
        dot(1, 0); check("R1 display off", 0, 0);
        set_ctl(1, 0, 0, 0, 0);
        dot(1, 0); check("R2 window invalid", 0, 0);
        dot(0, 0); check("R2 window invalid font0", 0, 0);
    endtask

    task automatic t_normal_reverse;
        set_ctl(1, 1, 0, 0, 0);
        dot(1, 0); check("R3 font1", 1, 0);
        dot(0, 0); check("R3 font0", 0, 1);
        dot(1, 1); check("R3 attr no blink", 1, 0);
        set_ctl(1, 1, 0, 0, 1);
        dot(1, 0); check("R4 reverse font1", 0, 1);
        dot(0, 0); check("R4 reverse font0", 1, 0);
    endtask

    task automatic t_short_blink;
        set_ctl(1, 1, 1, 0, 0);
        fields(14);
        dot(1, 1); check("R8 visible after 14", 1, 0);
        fields(1);
        dot(1, 1); check("R8 hidden after 15", 0, 0);
        check("R12 none while hidden", 0, 0);
        dot(0, 1); check("R6 hidden font0", 0, 0);
        dot(1, 0); check("R5 plain char hidden phase", 1, 0);
        dot(0, 0); check("R5 plain char font0", 0, 1);
        set_ctl(1, 1, 1, 0, 1);
        dot(1, 1); check("R7 hidden reverse plain font1", 1, 0);
        dot(0, 1); check("R7 hidden reverse plain font0", 0, 1);
        dot(1, 0); check("R4 reverse non-attr hidden", 0, 1);
        set_ctl(1, 1, 1, 0, 0);
        fields(15);
        dot(1, 1); check("R8 visible after 30", 1, 0);
        set_ctl(1, 1, 1, 0, 1);
        dot(1, 1); check("R7 visible reversed", 0, 1);
    endtask

    task automatic t_disable;
        set_ctl(1, 1, 0, 0, 0);
        set_ctl(1, 1, 1, 0, 0);
        fields(15);
        dot(1, 1); check("R10 setup hidden", 0, 0);
        set_ctl(1, 1, 0, 0, 0);
        dot(1, 1); check("R10 disable shows", 1, 0);
        set_ctl(1, 1, 1, 0, 0);
        fields(14);
        dot(1, 1); check("R10 count restarted", 1, 0);
        fields(1);
        dot(1, 1); check("R10 hidden after fresh 15", 0, 0);
    endtask

    task automatic t_long_blink;
        set_ctl(1, 1, 0, 1, 0);
        set_ctl(1, 1, 1, 1, 0);
        fields(29);
        dot(1, 1); check("R9 visible after 29", 1, 0);
        fields(1);
        dot(1, 1); check("R9 hidden after 30", 0, 0);
    endtask

    initial begin
        t_reset();
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        t_gating();
        t_normal_reverse();
        t_short_blink();
        t_disable();
        t_long_blink();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #500000;
        checks++;
        errors++;
        $display("FAIL watchdog: run did not complete");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule